// File: doc/BRIEF.md
# Descriptor Cookie Translator

This block turns a 20-bit descriptor cookie into the 64-bit virtual address of a descriptor by walking two tables. The upper part of the cookie is an index into a primary table that sits in a local on-chip memory. The entry found there gives the physical base of a secondary page. The lower part of the cookie picks one 8-byte slot in that page. The block reads that slot from host memory and returns its contents as the descriptor address. A client offers one cookie at a time on a valid/ready request port and collects the answer from a response port. The block drives a read port into the local table memory, which answers one cycle later. It also drives a read port into host memory, whose answer can take any number of cycles.

How a primary entry is read is fixed when the block is built. In the 4 KB-aligned build each entry is 4 bytes, so one 64-bit table word holds two entries. The page base is the 32-bit entry with twelve zero bits added at the bottom. In the unaligned build each entry is a full 64-bit word and is used as the page base exactly as it is stored. A cookie whose index lies past the end of the table gets an error response without any memory read. So does a cookie whose table entry is zero.

The sequencer has six states. IDLE accepts a request. TBL_FETCH issues the table read. TBL_EVAL looks at the returned entry. HOST_ISSUE sends the host read. HOST_WAIT waits for the host data. RESP holds the answer. The transitions are:
- IDLE→TBL_FETCH on an accepted in-range cookie.
- IDLE→RESP on an accepted out-of-range cookie.
- TBL_FETCH→TBL_EVAL always.
- TBL_EVAL→RESP on a zero entry.
- TBL_EVAL→HOST_ISSUE on a non-zero entry.
- HOST_ISSUE→HOST_WAIT always.
- HOST_WAIT→RESP when host data arrives.
- RESP→IDLE when the response is acknowledged.

Top module: `cookie_xlate`

## Requirements
- R1: Cookie bits 8:0 are the slot number and bits 19:9 are the primary index. The host read address is the page base plus 8 times the slot number.
- R2: In the aligned build the table word address is cookie bits 19:10. Cookie bit 9 = 1 selects entry bits 63:32 and bit 9 = 0 selects bits 31:0. The page base is that 32-bit entry shifted left by 12.
- R3: In the unaligned build the table word address is cookie bits 19:9, and the page base is the whole 64-bit table word.
- R4: The table depth is TBL_BYTES/4 entries in the aligned build and TBL_BYTES/8 in the unaligned build. A primary index at or above the depth gives an error response, and neither a table read nor a host read is issued.
- R5: A zero primary entry (the selected 32-bit half in the aligned build, the whole word in the unaligned build) gives an error response without a host read. Every error response carries zero data.
- R6: A successful response has rsp_err = 0 and rsp_data equal to the 64-bit word host memory returned for the slot address.
- R7: req_ready is high only in IDLE. A request is taken in a cycle where req_valid and req_ready are both high. A request offered in the same cycle as a response acknowledge is taken in the following cycle.
- R8: Once rsp_valid rises, it stays high with rsp_data and rsp_err unchanged until a cycle with rsp_ready high. The block then returns to IDLE.
- R9: Each accepted in-range cookie issues exactly one single-cycle table read, in the cycle after acceptance. Each successful lookup issues exactly one single-cycle host read.
- R10: After reset, req_ready is 1, and rsp_valid, tm_rd_en and hm_rd_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Cookie offered |
| req_ready | output | 1 | Block idle and able to take a cookie |
| req_cookie | input | COOKIE_W | Descriptor cookie |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response acknowledge |
| rsp_data | output | ADDR_W | Descriptor virtual address (zero on error) |
| rsp_err | output | 1 | Out-of-range index or zero entry |
| tm_rd_en | output | 1 | Table memory read strobe |
| tm_rd_addr | output | TBL_AW | Table memory 64-bit word address |
| tm_rd_data | input | ADDR_W | Table word, valid the cycle after the strobe |
| hm_rd_en | output | 1 | Host memory read strobe |
| hm_rd_addr | output | ADDR_W | Host byte address of the slot |
| hm_rd_valid | input | 1 | Host data valid |
| hm_rd_data | input | ADDR_W | Host slot contents |

## Verification
Two events can land in the same cycle: the acknowledge of a held response, and a new cookie offered on the request port. The bench raises rsp_ready and req_valid with a fresh cookie at the same clock edge. It checks that req_ready is low at that edge, so the new cookie is not taken. It then checks that one cycle later the response has dropped, req_ready is high, and the second cookie is taken and translated correctly without disturbing the first answer. Both the aligned and the unaligned build are run, using host latencies of one to six cycles.

// File: rtl/ckx_pkg.sv
package ckx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_TBL_FETCH  = 3'd1,
        ST_TBL_EVAL   = 3'd2,
        ST_HOST_ISSUE = 3'd3,
        ST_HOST_WAIT  = 3'd4,
        ST_RESP       = 3'd5
    } ckx_state_e;

endpackage

// File: rtl/ckx_cookie_split.sv
module ckx_cookie_split #(
    parameter int COOKIE_W = 20,
    parameter int SLOT_W   = 9,
    parameter int TBL_AW   = 10,
    parameter bit ALIGNED  = 1'b1,
    parameter int DEPTH    = 2048
) (
    input  logic [COOKIE_W-1:0] cookie,
    output logic [SLOT_W-1:0]   slot,
    output logic [TBL_AW-1:0]   word_addr,
    output logic                half_sel,
    output logic                in_range
);
    localparam int IDX_W = COOKIE_W - SLOT_W;

    logic [IDX_W-1:0] idx;

    assign slot     = cookie[SLOT_W-1:0];
    assign idx      = cookie[COOKIE_W-1:SLOT_W];
    assign in_range = (32'(idx) < 32'(DEPTH));

    generate
        if (ALIGNED) begin : g_aligned
            // two 4-byte entries share one 64-bit table word
            assign word_addr = cookie[SLOT_W+1 +: TBL_AW];
            assign half_sel  = cookie[SLOT_W];
        end else begin : g_unaligned
            assign word_addr = cookie[SLOT_W +: TBL_AW];
            assign half_sel  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/ckx_page_base.sv
module ckx_page_base #(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 12,
    parameter bit ALIGNED    = 1'b1
) (
    input  logic [ADDR_W-1:0] tbl_word,
    input  logic              half_sel,
    output logic [ADDR_W-1:0] page_base,
    output logic              entry_zero
);
    localparam int HALF_W = ADDR_W / 2;

    generate
        if (ALIGNED) begin : g_aligned
            logic [HALF_W-1:0] entry;
            assign entry      = half_sel ? tbl_word[ADDR_W-1:HALF_W] : tbl_word[HALF_W-1:0];
            assign page_base  = ADDR_W'(entry) << PAGE_SHIFT;
            assign entry_zero = (entry == '0);
        end else begin : g_unaligned
            logic unused_half;
            assign unused_half = half_sel;
            assign page_base   = tbl_word;
            assign entry_zero  = (tbl_word == '0);
        end
    endgenerate

endmodule

// File: rtl/ckx_ctrl.sv
module ckx_ctrl
    import ckx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       in_range,
    input  logic       entry_zero,
    input  logic       hm_rd_valid,
    input  logic       rsp_ready,
    output ckx_state_e state,
    output logic       req_ready,
    output logic       tm_rd_en,
    output logic       hm_rd_en,
    output logic       rsp_valid,
    output logic       load_cookie,
    output logic       load_addr,
    output logic       load_data,
    output logic       flag_err
);
    ckx_state_e state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nxt = in_range ? ST_TBL_FETCH : ST_RESP;
            ST_TBL_FETCH:  state_nxt = ST_TBL_EVAL;
            ST_TBL_EVAL:   state_nxt = entry_zero ? ST_RESP : ST_HOST_ISSUE;
            ST_HOST_ISSUE: state_nxt = ST_HOST_WAIT;
            ST_HOST_WAIT:  if (hm_rd_valid) state_nxt = ST_RESP;
            ST_RESP:       if (rsp_ready) state_nxt = ST_IDLE;
            default:       state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        tm_rd_en    = 1'b0;
        hm_rd_en    = 1'b0;
        rsp_valid   = 1'b0;
        load_cookie = 1'b0;
        load_addr   = 1'b0;
        load_data   = 1'b0;
        flag_err    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                req_ready   = 1'b1;
                load_cookie = req_valid;
                flag_err    = req_valid && !in_range;
            end
            ST_TBL_FETCH:  tm_rd_en = 1'b1;
            ST_TBL_EVAL: begin
                load_addr = !entry_zero;
                flag_err  = entry_zero;
            end
            ST_HOST_ISSUE: hm_rd_en = 1'b1;
            ST_HOST_WAIT:  load_data = hm_rd_valid;
            ST_RESP:       rsp_valid = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/cookie_xlate.sv
module cookie_xlate
    import ckx_pkg::*;
#(
    parameter int COOKIE_W   = 20,
    parameter int SLOT_W     = 9,
    parameter int ADDR_W     = 64,
    parameter int TBL_BYTES  = 8192,
    parameter bit ALIGNED    = 1'b1,
    parameter int PAGE_SHIFT = 12,
    localparam int TBL_AW    = $clog2(TBL_BYTES / 8)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [COOKIE_W-1:0] req_cookie,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [ADDR_W-1:0]   rsp_data,
    output logic                rsp_err,
    output logic                tm_rd_en,
    output logic [TBL_AW-1:0]   tm_rd_addr,
    input  logic [ADDR_W-1:0]   tm_rd_data,
    output logic                hm_rd_en,
    output logic [ADDR_W-1:0]   hm_rd_addr,
    input  logic                hm_rd_valid,
    input  logic [ADDR_W-1:0]   hm_rd_data
);
    localparam int ENTRY_BYTES = ALIGNED ? 4 : 8;
    localparam int DEPTH       = TBL_BYTES / ENTRY_BYTES;
    localparam int SLOT_SHIFT  = 3;

    ckx_state_e          state;
    logic [COOKIE_W-1:0] cookie_q;
    logic [COOKIE_W-1:0] split_src;
    logic [SLOT_W-1:0]   slot;
    logic                half_sel;
    logic                in_range;
    logic [ADDR_W-1:0]   page_base;
    logic                entry_zero;
    logic [ADDR_W-1:0]   slot_addr;
    logic [ADDR_W-1:0]   addr_q;
    logic [ADDR_W-1:0]   data_q;
    logic                err_q;
    logic                load_cookie, load_addr, load_data, flag_err;

    // incoming cookie is decoded while idle, the held one afterwards
    assign split_src = (state == ST_IDLE) ? req_cookie : cookie_q;

    ckx_cookie_split #(
        .COOKIE_W (COOKIE_W),
        .SLOT_W   (SLOT_W),
        .TBL_AW   (TBL_AW),
        .ALIGNED  (ALIGNED),
        .DEPTH    (DEPTH)
    ) u_split (
        .cookie    (split_src),
        .slot      (slot),
        .word_addr (tm_rd_addr),
        .half_sel  (half_sel),
        .in_range  (in_range)
    );

    ckx_page_base #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .ALIGNED    (ALIGNED)
    ) u_base (
        .tbl_word   (tm_rd_data),
        .half_sel   (half_sel),
        .page_base  (page_base),
        .entry_zero (entry_zero)
    );

    assign slot_addr = page_base + (ADDR_W'(slot) << SLOT_SHIFT);

    ckx_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .in_range    (in_range),
        .entry_zero  (entry_zero),
        .hm_rd_valid (hm_rd_valid),
        .rsp_ready   (rsp_ready),
        .state       (state),
        .req_ready   (req_ready),
        .tm_rd_en    (tm_rd_en),
        .hm_rd_en    (hm_rd_en),
        .rsp_valid   (rsp_valid),
        .load_cookie (load_cookie),
        .load_addr   (load_addr),
        .load_data   (load_data),
        .flag_err    (flag_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cookie_q <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            err_q    <= 1'b0;
        end else begin
            if (load_cookie) cookie_q <= req_cookie;
            if (load_addr)   addr_q   <= slot_addr;
            if (flag_err) begin
                data_q <= '0;
                err_q  <= 1'b1;
            end else if (load_data) begin
                data_q <= hm_rd_data;
                err_q  <= 1'b0;
            end
        end
    end

    assign hm_rd_addr = addr_q;
    assign rsp_data   = data_q;
    assign rsp_err    = err_q;

endmodule

// File: rtl/ckx_checker.sv
module ckx_checker #(
    parameter int COOKIE_W  = 20,
    parameter int SLOT_W    = 9,
    parameter int ADDR_W    = 64,
    parameter int TBL_BYTES = 8192,
    parameter bit ALIGNED   = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic [COOKIE_W-1:0] req_cookie,
    input logic                rsp_valid,
    input logic                rsp_ready,
    input logic [ADDR_W-1:0]   rsp_data,
    input logic                rsp_err,
    input logic                tm_rd_en,
    input logic                hm_rd_en
);
    localparam int DEPTH = TBL_BYTES / (ALIGNED ? 4 : 8);

    logic idx_ok;
    logic take;
    assign idx_ok = (32'(req_cookie[COOKIE_W-1:SLOT_W]) < 32'(DEPTH));
    assign take   = req_valid && req_ready;

    assert_resp_hold_R8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));

    assert_busy_after_take_R7: assert property (@(posedge clk) disable iff (rst)
        take |=> !req_ready);

    assert_ready_resp_excl_R7: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    assert_range_no_read_R4: assert property (@(posedge clk) disable iff (rst)
        take && !idx_ok |=> !tm_rd_en && rsp_valid && rsp_err);

    assert_fetch_after_take_R9: assert property (@(posedge clk) disable iff (rst)
        take && idx_ok |=> tm_rd_en);

    assert_tm_single_R9: assert property (@(posedge clk) disable iff (rst)
        tm_rd_en |=> !tm_rd_en);

    assert_hm_single_R9: assert property (@(posedge clk) disable iff (rst)
        hm_rd_en |=> !hm_rd_en);

    assert_err_zero_data_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_err |-> rsp_data == '0);

endmodule

bind cookie_xlate ckx_checker #(
    .COOKIE_W  (COOKIE_W),
    .SLOT_W    (SLOT_W),
    .ADDR_W    (ADDR_W),
    .TBL_BYTES (TBL_BYTES),
    .ALIGNED   (ALIGNED)
) u_chk (.*);

// File: tb/tb_cookie_xlate.sv
`timescale 1ns/1ps
module tb_cookie_xlate;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [1:0]  req_valid = '0;
    logic [1:0]  rsp_ready = '0;
    logic [19:0] req_cookie [2];
    logic [1:0]  req_ready, rsp_valid, rsp_err, tm_en, hm_en;
    logic [1:0]  hm_valid = '0;
    logic [63:0] rsp_data [2];
    logic [63:0] tm_data  [2];
    logic [63:0] hm_addr  [2];
    logic [63:0] hm_data  [2];
    logic [8:0]  tm_addr_a;
    logic [9:0]  tm_addr_u;

    int total = 0;
    int bad   = 0;
    int hm_lat   [2] = '{1, 1};
    int tm_reads [2] = '{0, 0};
    int hm_reads [2] = '{0, 0};
    int hm_cnt   [2] = '{0, 0};
    logic [1:0]  hm_busy = '0;
    logic [63:0] hm_q      [2];
    logic [63:0] last_addr [2];

    // aligned build, 4096-byte table: 1024 entries
    cookie_xlate #(.TBL_BYTES(4096), .ALIGNED(1'b1)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid[0]), .req_ready(req_ready[0]), .req_cookie(req_cookie[0]),
        .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready[0]),
        .rsp_data(rsp_data[0]), .rsp_err(rsp_err[0]),
        .tm_rd_en(tm_en[0]), .tm_rd_addr(tm_addr_a), .tm_rd_data(tm_data[0]),
        .hm_rd_en(hm_en[0]), .hm_rd_addr(hm_addr[0]),
        .hm_rd_valid(hm_valid[0]), .hm_rd_data(hm_data[0])
    );

    // unaligned build, 8192-byte table: 1024 entries
    cookie_xlate #(.TBL_BYTES(8192), .ALIGNED(1'b0)) dut_u (
        .clk(clk), .rst(rst),
        .req_valid(req_valid[1]), .req_ready(req_ready[1]), .req_cookie(req_cookie[1]),
        .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready[1]),
        .rsp_data(rsp_data[1]), .rsp_err(rsp_err[1]),
        .tm_rd_en(tm_en[1]), .tm_rd_addr(tm_addr_u), .tm_rd_data(tm_data[1]),
        .hm_rd_en(hm_en[1]), .hm_rd_addr(hm_addr[1]),
        .hm_rd_valid(hm_valid[1]), .hm_rd_data(hm_data[1])
    );

    function automatic logic [63:0] tbl_word(int m, logic [10:0] w);
        logic [31:0] lo, hi;
        if (m == 0) begin
            lo = (w == 11'd5) ? 32'h0 : (32'h000A_0000 | 32'(w));
            hi = 32'h000B_0000 | 32'(w);
            return {hi, lo};
        end
        if (w == 11'd7) return 64'h0;
        return 64'h0000_0012_3456_0000 + 64'(w) * 64'h48 + 64'h3;
    endfunction

    function automatic logic [63:0] host_word(logic [63:0] a);
        return {~a[31:0], a[31:0]} ^ 64'h5A00_0000_0000_00C3;
    endfunction

    function automatic logic [63:0] page_of(int m, logic [19:0] c);
        logic [63:0] w;
        logic [31:0] e;
        if (m == 0) begin
            w = tbl_word(0, {1'b0, c[19:10]});
            e = c[9] ? w[63:32] : w[31:0];
            return {20'h0, e, 12'h0};
        end
        return tbl_word(1, c[19:9]);
    endfunction

    // memory models
    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if (tm_en[m]) begin
                tm_data[m]  <= tbl_word(m, (m == 0) ? 11'(tm_addr_a) : 11'(tm_addr_u));
                tm_reads[m] <= tm_reads[m] + 1;
            end
            hm_valid[m] <= 1'b0;
            if (rst) begin
                hm_busy[m] <= 1'b0;
            end else if (hm_en[m]) begin
                hm_q[m]      <= hm_addr[m];
                last_addr[m] <= hm_addr[m];
                hm_cnt[m]    <= hm_lat[m];
                hm_busy[m]   <= 1'b1;
                hm_reads[m]  <= hm_reads[m] + 1;
            end else if (hm_busy[m]) begin
                if (hm_cnt[m] == 1) begin
                    hm_valid[m] <= 1'b1;
                    hm_data[m]  <= host_word(hm_q[m]);
                    hm_busy[m]  <= 1'b0;
                end else begin
                    hm_cnt[m] <= hm_cnt[m] - 1;
                end
            end
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // offer a cookie and wait until it is taken
    task automatic offer(int m, logic [19:0] c);
        @(negedge clk);
        req_cookie[m] = c;
        req_valid[m]  = 1'b1;
        while (!req_ready[m]) @(negedge clk);
        @(posedge clk);
        #1 req_valid[m] = 1'b0;
    endtask

    // one full lookup, checked against the requirements
    task automatic run_xact(int m, logic [19:0] c, int lat, int hold, string tag);
        int  t0, h0;
        bit  in_rng, ok;
        logic [63:0] ea;
        hm_lat[m] = lat;
        t0 = tm_reads[m];
        h0 = hm_reads[m];
        in_rng = int'(c[19:9]) < 1024;
        ok     = in_rng && (page_of(m, c) != 64'h0);
        ea     = page_of(m, c) + {52'h0, c[8:0], 3'b000};
        offer(m, c);
        @(negedge clk);
        chk({tag, " R9/R4 table strobe after accept"}, 64'(tm_en[m]), 64'(in_rng));
        while (!rsp_valid[m]) @(negedge clk);
        if (hold > 0) begin
            logic [63:0] d0;
            d0 = rsp_data[m];
            repeat (hold) @(negedge clk);
            chk({tag, " R8 valid held"}, 64'(rsp_valid[m]), 64'h1);
            chk({tag, " R8 data held"}, rsp_data[m], d0);
        end
        chk({tag, " R4/R5/R6 err"}, 64'(rsp_err[m]), 64'(!ok));
        chk({tag, " R1/R5/R6 data"}, rsp_data[m], ok ? host_word(ea) : 64'h0);
        rsp_ready[m] = 1'b1;
        @(posedge clk);
        #1 rsp_ready[m] = 1'b0;
        @(negedge clk);
        chk({tag, " R8 back to idle"}, {62'h0, rsp_valid[m], req_ready[m]}, 64'h1);
        chk({tag, " R9 table reads"}, 64'(tm_reads[m] - t0), 64'(in_rng));
        chk({tag, " R9 host reads"}, 64'(hm_reads[m] - h0), 64'(ok));
        if (ok) chk({tag, " R1 host address"}, last_addr[m], ea);
    endtask

    // response acknowledge and new request in the same cycle
    task automatic collide(int m, logic [19:0] c1, logic [19:0] c2);
        logic [63:0] ea;
        hm_lat[m] = 2;
        offer(m, c1);
        while (!rsp_valid[m]) @(negedge clk);
        req_cookie[m] = c2;
        req_valid[m]  = 1'b1;
        rsp_ready[m]  = 1'b1;
        chk("R7 no take while responding", 64'(req_ready[m]), 64'h0);
        @(posedge clk);
        #1 rsp_ready[m] = 1'b0;
        @(negedge clk);
        chk("R7 idle one cycle after ack", {62'h0, rsp_valid[m], req_ready[m]}, 64'h1);
        @(posedge clk);
        #1 req_valid[m] = 1'b0;
        @(negedge clk);
        chk("R7 second cookie fetched", 64'(tm_en[m]), 64'h1);
        while (!rsp_valid[m]) @(negedge clk);
        ea = page_of(m, c2) + {52'h0, c2[8:0], 3'b000};
        chk("R7 second cookie data", rsp_data[m], host_word(ea));
        rsp_ready[m] = 1'b1;
        @(posedge clk);
        #1 rsp_ready[m] = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        req_cookie[0] = '0;
        req_cookie[1] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int m = 0; m < 2; m++)
            chk("R10 reset state", {60'h0, req_ready[m], rsp_valid[m], tm_en[m], hm_en[m]}, 64'h8);

        // aligned build
        run_xact(0, {11'd4,    9'd3},   1, 0, "R2 even index low half");
        run_xact(0, {11'd5,    9'd511}, 3, 0, "R2 odd index high half");
        run_xact(0, {11'd10,   9'd8},   1, 0, "R5 aligned zero half");
        run_xact(0, {11'd11,   9'd0},   2, 0, "R2 other half nonzero");
        run_xact(0, {11'd1023, 9'd0},   1, 0, "R4 aligned last index");
        run_xact(0, {11'd1024, 9'd1},   1, 0, "R4 aligned past depth");
        run_xact(0, {11'd2047, 9'd511}, 1, 0, "R4 aligned max index");
        run_xact(0, {11'd6,    9'd77},  4, 5, "R8 aligned hold");

        // unaligned build
        run_xact(1, {11'd0,    9'd0},   2, 0, "R3 first entry");
        run_xact(1, {11'd300,  9'd17},  6, 0, "R3 mid entry");
        run_xact(1, {11'd1023, 9'd511}, 1, 0, "R3 last entry max slot");
        run_xact(1, {11'd7,    9'd4},   1, 0, "R5 unaligned zero word");
        run_xact(1, {11'd1024, 9'd0},   1, 0, "R4 unaligned past depth");
        run_xact(1, {11'd9,    9'd2},   3, 4, "R8 unaligned hold");

        collide(1, {11'd12, 9'd1}, {11'd13, 9'd2});
        collide(0, {11'd20, 9'd5}, {11'd21, 9'd6});

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule